// File: doc/BRIEF.md
# Dual External Interrupt Condition Unit

This unit prepares two active-low external interrupt pins for a small 8-bit processor core. Each pin is brought into the clock domain through a two-stage synchronizer. A falling transition on the synchronized value is captured in a per-line pending flag. A per-line mode bit selects the trigger. In edge mode only the captured falling transition counts. In level mode a pin that is still held low also counts. Level mode lets several open-drain sources share one pin: a source that is still low after the flag is cleared gets serviced again.

A per-line enable bit gates each line into one interrupt request toward the core. The core's interrupt-mask input gates that request. The service routine clears a line's pending flag with an acknowledge strobe. The flag is a single bit, so after the acknowledge it can hold only one more pulse, however many pulses arrive before the next service. Software reaches the mode and enable bits through two byte-wide registers on a simple write/read bus. Each register also holds timer-control bits that this unit only stores.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset no request is raised while the pins stay high. A pin going from high to low is captured in its pending flag on the third rising clock edge after the change, counting the two synchronizer stages.
- R2: With a line's mode bit at 1 (edge mode), a pin held low raises the request only through the pending flag. Once that flag is acknowledged, the request drops even though the pin is still low.
- R3: With a line's mode bit at 0 (level mode), the request is raised while the synchronized pin is low, both before and after an acknowledge. A falling transition is also captured in the pending flag.
- R4: A line whose enable bit is 0 never raises the request. Its pending flag still captures transitions, and a held flag raises the request as soon as the enable bit is set.
- R5: While the core's mask input is 1 the request is 0. Pending events are kept and reappear when the mask goes back to 0.
- R6: An acknowledge on a line clears that line's pending flag on the next rising edge. Any number of pulses that arrive afterwards leave just one pending event, which a single acknowledge removes.
- R7: If a captured falling transition and that line's acknowledge fall on the same clock edge, the pending flag stays set.
- R8: The option register sits at address 0x35 and resets to 0x00. Bit 4 is the mode bit of line 0 and bit 3 is the mode bit of line 1. Bits 6 and 5 are stored timer bits.
- R9: The enable register sits at address 0x16 and resets to 0x00. Bit 6 enables line 0 and bit 5 enables line 1. Bit 7 is a stored timer bit.
- R10: Unused bits read 0 and ignore writes: 7 and 2..0 of the option register, 4..0 of the enable register. Stored timer bits read back as last written. Reads of any other address return 0x00, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPinN | input | 2 | External interrupt pins, active low, bit i is line i |
| ackLine | input | 2 | Per-line acknowledge strobe that clears the pending flag |
| cpuMask | input | 1 | Core interrupt mask, 1 blocks the request |
| busAddr | input | 8 | Register address |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| cpuIrq | output | 1 | Interrupt request toward the core |

## Verification
The critical collision is a freshly captured falling transition meeting the acknowledge of the same line on one clock edge. The set must win, or the event is lost. The bench drives the pin low, waits exactly two rising edges so that the synchronized transition lands on the third, and raises the acknowledge for that edge. It then judges the pending flag through the request output against a behavioural model that sets before it clears. A second overlap combines a held low level in level mode with an acknowledge. The request must stay up in that case, while in edge mode the same stimulus must drop it.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int NUM_LINES   = 2;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] OPT_ADDR = 8'h35;
  localparam logic [ADDR_W-1:0] ENA_ADDR = 8'h16;

  // line i mode bit sits at OPT_MODE_TOP - i, enable bit at ENA_LINE_TOP - i
  localparam int OPT_MODE_TOP = 4;
  localparam int ENA_LINE_TOP = 6;
  localparam logic [DATA_W-1:0] OPT_TMR_MASK = 8'h60;
  localparam logic [DATA_W-1:0] ENA_TMR_MASK = 8'h80;

  function automatic logic [DATA_W-1:0] lineMask(input int top);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_LINES; i++) m[top-i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] OPT_WR_MASK = OPT_TMR_MASK | lineMask(OPT_MODE_TOP);
  localparam logic [DATA_W-1:0] ENA_WR_MASK = ENA_TMR_MASK | lineMask(ENA_LINE_TOP);

  typedef struct packed {
    logic optWr;
    logic enaWr;
    logic optSel;
    logic enaSel;
  } regStrobe_t;
endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output regStrobe_t        strb
);
  logic hitOpt;
  logic hitEna;

  assign hitOpt = (busAddr == OPT_ADDR);
  assign hitEna = (busAddr == ENA_ADDR);

  always_comb begin
    strb.optSel = hitOpt;
    strb.enaSel = hitEna;
    strb.optWr  = hitOpt & busWr;
    strb.enaWr  = hitEna & busWr;
  end
endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extPinN,
  input  logic [NUM_LINES-1:0] ackLine,
  input  logic                 cpuMask,
  input  logic [DATA_W-1:0]    wrData,
  input  regStrobe_t           strb,
  output logic [DATA_W-1:0]    rdData,
  output logic                 cpuIrq
);
  logic [DATA_W-1:0]    optReg;
  logic [DATA_W-1:0]    enaReg;
  logic [NUM_LINES-1:0] syncOut;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] fallEv;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] edgeOnly;
  logic [NUM_LINES-1:0] lineEn;
  logic [NUM_LINES-1:0] lineReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      optReg <= '0;
      enaReg <= '0;
    end else begin
      if (strb.optWr) optReg <= wrData & OPT_WR_MASK;
      if (strb.enaWr) enaReg <= wrData & ENA_WR_MASK;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.optSel)      rdData = optReg;
    else if (strb.enaSel) rdData = enaReg;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    logic [SYNC_STAGES-1:0] syncQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ    <= '1;
        prevQ[i] <= 1'b1;
      end else begin
        syncQ    <= {syncQ[SYNC_STAGES-2:0], extPinN[i]};
        prevQ[i] <= syncQ[SYNC_STAGES-1];
      end
    end

    assign syncOut[i]  = syncQ[SYNC_STAGES-1];
    assign fallEv[i]   = prevQ[i] & ~syncOut[i];
    assign edgeOnly[i] = optReg[OPT_MODE_TOP-i];
    assign lineEn[i]   = enaReg[ENA_LINE_TOP-i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pending[i] <= 1'b0;
      else if (fallEv[i]) pending[i] <= 1'b1;
      else if (ackLine[i]) pending[i] <= 1'b0;
    end

    assign lineReq[i] = lineEn[i] & (pending[i] | (~edgeOnly[i] & ~syncOut[i]));

    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rstN)
      fallEv[i] |=> pending[i]); // R1
    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pending[i]) |-> $past(fallEv[i])); // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (ackLine[i] && !fallEv[i]) |=> !pending[i]); // R6
    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
      (ackLine[i] && fallEv[i]) |=> pending[i]); // R7
    AST_LEVEL_REQUESTS: assert property (@(posedge clk) disable iff (!rstN)
      (!edgeOnly[i] && lineEn[i] && !syncOut[i] && !cpuMask) |-> cpuIrq); // R3
  end

  assign cpuIrq = (|lineReq) & ~cpuMask;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import extirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extPinN,
  input  logic [NUM_LINES-1:0] ackLine,
  input  logic                 cpuMask,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 cpuIrq
);
  regStrobe_t strb;

  extirq_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strb    (strb)
  );

  extirq_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .extPinN (extPinN),
    .ackLine (ackLine),
    .cpuMask (cpuMask),
    .wrData  (busWrData),
    .strb    (strb),
    .rdData  (busRdData),
    .cpuIrq  (cpuIrq)
  );

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    cpuMask |-> !cpuIrq); // R5
  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != OPT_ADDR && busAddr != ENA_ADDR) |-> (busRdData == '0)); // R10
endmodule

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extPinN = 2'b11;
  logic [1:0] ackLine = 2'b00;
  logic       cpuMask = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       cpuIrq;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  ext_irq_detect dut_i (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .ackLine(ackLine),
    .cpuMask(cpuMask), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .cpuIrq(cpuIrq)
  );

  // behavioural reference
  logic [7:0] mOpt, mEna;
  logic [1:0] mS1, mS2, mPrev, mPend;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOpt = 0; mEna = 0; mS1 = 2'b11; mS2 = 2'b11; mPrev = 2'b11; mPend = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (mPrev[i] && !mS2[i]) mPend[i] = 1'b1;
        else if (ackLine[i])     mPend[i] = 1'b0;
      end
      mPrev = mS2; mS2 = mS1; mS1 = extPinN;
      if (busWr && busAddr == 8'h35) mOpt = busWrData & 8'h78;
      if (busWr && busAddr == 8'h16) mEna = busWrData & 8'hE0;
    end
  end

  function automatic bit expIrq();
    bit r = 0;
    bit edgeMode [2];
    bit en [2];
    edgeMode[0] = mOpt[4]; edgeMode[1] = mOpt[3];
    en[0] = mEna[6];       en[1] = mEna[5];
    for (int i = 0; i < 2; i++)
      if (en[i] && (mPend[i] || (!edgeMode[i] && !mS2[i]))) r = 1;
    return r && !cpuMask;
  endfunction

  function automatic logic [7:0] expRd();
    if (busAddr == 8'h35) return mOpt;
    if (busAddr == 8'h16) return mEna;
    return 8'h00;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && !done) begin
    check(curReq, "cpuIrq vs model", cpuIrq, expIrq());
    check(curReq, "rdData vs model", busRdData, expRd());
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1; cyc(1); busWr = 0; busAddr = 8'h00;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] a, input logic [7:0] exp);
    busAddr = a; #1;
    check(req, "register read", busRdData, exp);
    busAddr = 8'h00;
  endtask

  task automatic irqCheck(input string req, input bit exp);
    @(negedge clk); #1;
    check(req, "cpuIrq directed", cpuIrq, exp);
    cyc(1);
  endtask

  task automatic pulse(input int ln, input int width);
    extPinN[ln] = 0; cyc(width); extPinN[ln] = 1;
  endtask

  task automatic ack(input int ln);
    ackLine[ln] = 1; cyc(1); ackLine[ln] = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    cyc(3); rstN = 1; cyc(1);
    // reset state
    rdCheck("R8", 8'h35, 8'h00);
    rdCheck("R9", 8'h16, 8'h00);
    cyc(4); irqCheck("R1", 0);

    curReq = "R10";
    wr(8'h35, 8'hFF); rdCheck("R10", 8'h35, 8'h78);
    wr(8'h16, 8'hFF); rdCheck("R10", 8'h16, 8'hE0);
    wr(8'h20, 8'hFF); rdCheck("R10", 8'h20, 8'h00);
    rdCheck("R10", 8'h35, 8'h78);
    wr(8'h35, 8'h60); rdCheck("R8", 8'h35, 8'h60);
    wr(8'h16, 8'h80); rdCheck("R9", 8'h16, 8'h80);
    wr(8'h35, 8'h00); wr(8'h16, 8'h00);

    // disabled line keeps its pending event
    curReq = "R4";
    pulse(0, 3); cyc(4); irqCheck("R4", 0);
    wr(8'h16, 8'h40); irqCheck("R4", 1);
    ack(0); irqCheck("R4", 0);

    // edge mode: held low does not re-request
    curReq = "R2";
    wr(8'h35, 8'h18); wr(8'h16, 8'h60);
    extPinN[1] = 0; cyc(2); irqCheck("R1", 0);
    irqCheck("R1", 1);
    ack(1); cyc(2); irqCheck("R2", 0);
    extPinN[1] = 1; cyc(4);

    // level mode: held low re-requests after ack
    curReq = "R3";
    wr(8'h35, 8'h00);
    extPinN[1] = 0; cyc(4); irqCheck("R3", 1);
    ack(1); cyc(2); irqCheck("R3", 1);
    extPinN[1] = 1; cyc(3); irqCheck("R3", 0);

    // one pending event survives several pulses
    curReq = "R6";
    wr(8'h35, 8'h18);
    pulse(0, 2); cyc(4); ack(0); cyc(1); irqCheck("R6", 0);
    cpuMask = 1;
    for (int k = 0; k < 3; k++) begin pulse(0, 2); cyc(2); end
    cyc(3);
    curReq = "R5";
    irqCheck("R5", 0);
    cpuMask = 0; irqCheck("R5", 1);
    curReq = "R6";
    ack(0); cyc(1); irqCheck("R6", 0);

    // edge and ack on the same edge
    curReq = "R7";
    pulse(1, 2); cyc(4); irqCheck("R7", 1);
    extPinN[0] = 1; extPinN[1] = 0; cyc(2);
    ackLine[1] = 1; cyc(1); ackLine[1] = 0;
    irqCheck("R7", 1);
    extPinN[1] = 1; ack(1); cyc(2); irqCheck("R7", 0);

    // both lines with mixed modes
    curReq = "R3";
    wr(8'h35, 8'h10);
    extPinN = 2'b00; cyc(4); irqCheck("R3", 1);
    ack(0); ack(1); irqCheck("R3", 1);
    extPinN = 2'b11; cyc(4); irqCheck("R3", 0);

    cyc(3);
    finishRun();
  end
endmodule